// File: doc/BRIEF.md
# System Control Register Block

This block is the control and status register file of a small microcontroller subsystem. It decodes a 4 KB byte-addressed window on a simple 32-bit register bus. A write is taken on any clock edge where the write strobe is high. Read data is a combinational function of the address. The bus bridge reports the access width on a size input, and a narrow write stores its data zero-extended to 32 bits.

The block holds seven storage words:
- a debug-permission word, changed only through separate set and clear aliases;
- a reset cause word and a reset mask;
- a retention scratch word;
- a boot vector;
- a processor hold word;
- a wake-up controller control word.

It also has a write-only reset trigger, a reserved word that reads zero, and a read-only bank of twelve identification bytes. A write to the trigger with bit 9 set produces a registered one-cycle reset request pulse. The block's storage is cleared only by its own power-on reset input.

Top module: `sysctl_regblock`

## Requirements
- R1: After power-on reset the words read as follows: reset cause (0x100) = 0x00000001, boot vector (0x110) = 0x10000000, and debug word (0x000), reset mask (0x104), retention (0x10C), processor hold (0x118) and wake control (0x120) = 0.
- R2: A write to 0x004 ORs the (zero-extended) write data into the debug word.
- R3: A write to 0x008 clears in the debug word every bit that is 1 in the write data.
- R4: Offsets 0x004, 0x008 and 0x108 are write-only and read as zero.
- R5: A write to 0x108 whose effective data has bit 9 set drives sys_reset_req high for exactly the cycle after the write. Any other access leaves it low, including a write to 0x108 with bit 9 clear.
- R6: The words at 0x100, 0x104, 0x10C, 0x110, 0x118 and 0x120 read back the last value written to them.
- R7: A write to 0x000, to 0x11C or to the ID range changes nothing. 0x11C always reads zero.
- R8: Words 0xFD0 to 0xFFC read, in rising address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, each in bits 7:0 with upper bits zero.
- R9: A read of any other offset returns zero, and a write to one changes no state.
- R10: bus_size 0 keeps write data bits 7:0, bus_size 1 keeps bits 15:0, and bus_size 2 or 3 keeps all 32 bits. The other bits are stored as zero. Address bits 1:0 are ignored.
- R11: A reset request pulse leaves every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sys_reset_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench sets debug bits and then clears overlapping patterns through the aliases. A design that swaps or merges the set and clear aliases leaves stale or missing bits. The bench writes the reset trigger with bit 9 both set and clear, using full-width and narrow writes. This exposes a pulse that lasts too long, a pulse that arrives a cycle late, and a trigger that ignores the zero-extension of a byte write. It also writes to the status word, the reserved word, the ID bank and unmapped offsets, then reads every stored word back. A decoder with an aliased or widened range would corrupt a neighbouring register. A reset request followed by a full readback catches storage that the block's own pulse clears.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int WORD_W = ADDR_W - 2;
    localparam int ID_CNT = 12;
    localparam int ID_IDX_W = $clog2(ID_CNT);

    // Word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_DBG      = WORD_W'(12'h000 >> 2);
    localparam logic [WORD_W-1:0] W_DBG_SET  = WORD_W'(12'h004 >> 2);
    localparam logic [WORD_W-1:0] W_DBG_CLR  = WORD_W'(12'h008 >> 2);
    localparam logic [WORD_W-1:0] W_CAUSE    = WORD_W'(12'h100 >> 2);
    localparam logic [WORD_W-1:0] W_MASK     = WORD_W'(12'h104 >> 2);
    localparam logic [WORD_W-1:0] W_TRIG     = WORD_W'(12'h108 >> 2);
    localparam logic [WORD_W-1:0] W_RETAIN   = WORD_W'(12'h10C >> 2);
    localparam logic [WORD_W-1:0] W_BOOT     = WORD_W'(12'h110 >> 2);
    localparam logic [WORD_W-1:0] W_HOLD     = WORD_W'(12'h118 >> 2);
    localparam logic [WORD_W-1:0] W_RSVD     = WORD_W'(12'h11C >> 2);
    localparam logic [WORD_W-1:0] W_WAKE     = WORD_W'(12'h120 >> 2);
    localparam logic [WORD_W-1:0] W_ID_FIRST = WORD_W'(12'hFD0 >> 2);

    localparam int TRIG_BIT = 9;
    localparam logic [DATA_W-1:0] CAUSE_INIT = 32'h0000_0001;
    localparam logic [DATA_W-1:0] BOOT_INIT  = 32'h1000_0000;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DBG, SEL_DBG_SET, SEL_DBG_CLR, SEL_CAUSE, SEL_MASK,
        SEL_TRIG, SEL_RETAIN, SEL_BOOT, SEL_HOLD, SEL_RSVD, SEL_WAKE, SEL_ID
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] dbg;
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] retain;
        logic [DATA_W-1:0] boot;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] wake;
    } ctl_state_t;

    function automatic logic [DATA_W-1:0] pad_by_size(input logic [DATA_W-1:0] d,
                                                      input logic [1:0] sz);
        logic [DATA_W-1:0] r;
        case (sz)
            2'd0:    r = {{(DATA_W-8){1'b0}},  d[7:0]};
            2'd1:    r = {{(DATA_W-16){1'b0}}, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] i);
        logic [7:0] b;
        case (i)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h54;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h0B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    output reg_sel_e            sel,
    output logic [ID_IDX_W-1:0] id_idx
);
    logic [WORD_W-1:0] id_off;
    assign id_off = word - W_ID_FIRST;
    assign id_idx = id_off[ID_IDX_W-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (word >= W_ID_FIRST) begin
            sel = SEL_ID;
        end else begin
            case (word)
                W_DBG:     sel = SEL_DBG;
                W_DBG_SET: sel = SEL_DBG_SET;
                W_DBG_CLR: sel = SEL_DBG_CLR;
                W_CAUSE:   sel = SEL_CAUSE;
                W_MASK:    sel = SEL_MASK;
                W_TRIG:    sel = SEL_TRIG;
                W_RETAIN:  sel = SEL_RETAIN;
                W_BOOT:    sel = SEL_BOOT;
                W_HOLD:    sel = SEL_HOLD;
                W_RSVD:    sel = SEL_RSVD;
                W_WAKE:    sel = SEL_WAKE;
                default:   sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output ctl_state_t        st,
    output logic              rst_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st.dbg    <= '0;
            st.cause  <= CAUSE_INIT;
            st.mask   <= '0;
            st.retain <= '0;
            st.boot   <= BOOT_INIT;
            st.hold   <= '0;
            st.wake   <= '0;
            rst_req   <= 1'b0;
        end else begin
            rst_req <= wr_en && (sel == SEL_TRIG) && wdata[TRIG_BIT];
            if (wr_en) begin
                case (sel)
                    SEL_DBG_SET: st.dbg    <= st.dbg | wdata;
                    SEL_DBG_CLR: st.dbg    <= st.dbg & ~wdata;
                    SEL_CAUSE:   st.cause  <= wdata;
                    SEL_MASK:    st.mask   <= wdata;
                    SEL_RETAIN:  st.retain <= wdata;
                    SEL_BOOT:    st.boot   <= wdata;
                    SEL_HOLD:    st.hold   <= wdata;
                    SEL_WAKE:    st.wake   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    AST_DBG_SET_ORS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DBG_SET) |=> ((st.dbg & $past(wdata)) == $past(wdata))); // R2
    AST_DBG_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DBG_CLR) |=> ((st.dbg & $past(wdata)) == '0)); // R3
    AST_DBG_ONLY_ALIASES: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (sel == SEL_DBG_SET || sel == SEL_DBG_CLR)) |=> $stable(st.dbg)); // R7
    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(wr_en && sel == SEL_TRIG && wdata[TRIG_BIT])); // R5
    AST_RETAIN_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_RETAIN) |=> (st.retain == $past(wdata))); // R6
endmodule

// File: rtl/sysctl_regblock.sv
module sysctl_regblock
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_reset_req
);
    reg_sel_e            sel;
    logic [ID_IDX_W-1:0] id_idx;
    logic [DATA_W-1:0]   wdata_eff;
    ctl_state_t          st;
    logic                unused_lane_bits;

    assign unused_lane_bits = ^bus_addr[1:0];
    assign wdata_eff = pad_by_size(bus_wdata, bus_size);

    sysctl_decode i_decode (
        .word   (bus_addr[ADDR_W-1:2]),
        .sel    (sel),
        .id_idx (id_idx)
    );

    sysctl_store i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .sel     (sel),
        .wdata   (wdata_eff),
        .st      (st),
        .rst_req (sys_reset_req)
    );

    always_comb begin
        case (sel)
            SEL_DBG:    bus_rdata = st.dbg;
            SEL_CAUSE:  bus_rdata = st.cause;
            SEL_MASK:   bus_rdata = st.mask;
            SEL_RETAIN: bus_rdata = st.retain;
            SEL_BOOT:   bus_rdata = st.boot;
            SEL_HOLD:   bus_rdata = st.hold;
            SEL_WAKE:   bus_rdata = st.wake;
            SEL_ID:     bus_rdata = {{(DATA_W-8){1'b0}}, id_byte(id_idx)};
            default:    bus_rdata = '0;
        endcase
    end

    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:2] == W_DBG_SET || bus_addr[ADDR_W-1:2] == W_DBG_CLR ||
         bus_addr[ADDR_W-1:2] == W_TRIG) |-> (bus_rdata == '0)); // R4
    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[ADDR_W-1:2] >= W_ID_FIRST) |-> (bus_rdata[DATA_W-1:8] == '0)); // R8
endmodule

// File: tb/test_sysctl_regblock.sv
`timescale 1ns/1ps
module test_sysctl_regblock;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_dbg, m_cause, m_mask, m_ret, m_boot, m_hold, m_wake;

    always #2.5 clk = ~clk;

    sysctl_regblock i_sysctl_regblock (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_reset_req(sys_reset_req)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pad(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'd0) return {24'h0, d[7:0]};
        if (sz == 2'd1) return {16'h0, d[15:0]};
        return d;
    endfunction

    function automatic logic [7:0] exp_id(input int i);
        logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                               8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[i];
    endfunction

    task automatic model_reset();
        m_dbg = 0; m_cause = 32'h1; m_mask = 0; m_ret = 0;
        m_boot = 32'h1000_0000; m_hold = 0; m_wake = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [11:0] w;
        w = {a[11:2], 2'b00};
        if (w >= 12'hFD0) return {24'h0, exp_id(int'((w - 12'hFD0) >> 2))};
        case (w)
            12'h000: return m_dbg;
            12'h100: return m_cause;
            12'h104: return m_mask;
            12'h10C: return m_ret;
            12'h110: return m_boot;
            12'h118: return m_hold;
            12'h120: return m_wake;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case ({a[11:2], 2'b00})
            12'h004: m_dbg = m_dbg | d;
            12'h008: m_dbg = m_dbg & ~d;
            12'h100: m_cause = d;
            12'h104: m_mask = d;
            12'h10C: m_ret = d;
            12'h110: m_boot = d;
            12'h118: m_hold = d;
            12'h120: m_wake = d;
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
        logic [31:0] e;
        logic        exp_req;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        e = pad(d, sz);
        exp_req = (a[11:2] == 10'h042) && e[9];
        check(sys_reset_req === exp_req, "R5", "reset pulse after write",
              {31'h0, sys_reset_req}, {31'h0, exp_req});
        model_write(a, e);
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        logic [31:0] ex;
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        ex = model_read(a);
        check(bus_rdata === ex, req, $sformatf("read %03h", a), bus_rdata, ex);
        check(sys_reset_req === 1'b0, "R5", "pulse dropped", {31'h0, sys_reset_req}, 32'h0);
    endtask

    task automatic read_all(input string req);
        logic [11:0] lst [7] = '{12'h000, 12'h100, 12'h104, 12'h10C, 12'h110, 12'h118, 12'h120};
        foreach (lst[k]) do_read(lst[k], req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] pool [20] = '{12'h000, 12'h004, 12'h008, 12'h100, 12'h104, 12'h108,
                                  12'h10C, 12'h110, 12'h118, 12'h11C, 12'h120, 12'h0FC,
                                  12'h114, 12'h124, 12'hFCC, 12'hFD0, 12'hFE4, 12'hFFC,
                                  12'h10E, 12'h005};
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        read_all("R1");
        // R8 ID bank
        for (int i = 0; i < 12; i++) do_read(12'hFD0 + 12'(i * 4), "R8");
        // R2 / R3 aliases
        do_write(12'h004, 32'h0000_00F3, 2'd2); do_read(12'h000, "R2");
        do_write(12'h004, 32'h8000_0100, 2'd2); do_read(12'h000, "R2");
        do_write(12'h008, 32'h0000_0031, 2'd2); do_read(12'h000, "R3");
        // R4 write-only reads
        do_read(12'h004, "R4"); do_read(12'h008, "R4"); do_read(12'h108, "R4");
        // R7 ignored writes
        do_write(12'h000, 32'hFFFF_FFFF, 2'd2); do_read(12'h000, "R7");
        do_write(12'h11C, 32'hFFFF_FFFF, 2'd2); do_read(12'h11C, "R7");
        do_write(12'hFE0, 32'hFFFF_FFFF, 2'd2); do_read(12'hFE0, "R7");
        // R6 readback
        do_write(12'h10C, 32'hCAFE_F00D, 2'd2); do_read(12'h10C, "R6");
        do_write(12'h110, 32'h0000_2000, 2'd2); do_read(12'h110, "R6");
        // R10 narrow writes and ignored low address bits
        do_write(12'h10F, 32'h1234_5678, 2'd0); do_read(12'h10C, "R10");
        do_write(12'h122, 32'hABCD_9876, 2'd1); do_read(12'h120, "R10");
        do_write(12'h108, 32'h0000_0200, 2'd0); // byte write drops bit 9: no pulse, R10
        // R9 unmapped
        do_write(12'h114, 32'hFFFF_FFFF, 2'd2); do_read(12'h114, "R9");
        read_all("R9");
        // R5 / R11: trigger with and without bit 9, then readback
        do_write(12'h108, 32'hFFFF_FDFF, 2'd2);
        do_write(12'h108, 32'h0000_0200, 2'd2);
        read_all("R11");
        do_write(12'h108, 32'h0000_0200, 2'd1);
        do_write(12'h108, 32'h0000_0200, 2'd2);
        read_all("R11");

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            a = ($urandom % 5 == 0) ? 12'($urandom) : pool[$urandom % 20];
            if ($urandom % 10 < 6)
                do_write(a, $urandom, 2'($urandom % 4));
            else
                do_read(a, "R6");
        end
        read_all("R6");

        // R1 again after power-on reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        read_all("R1");
        check(sys_reset_req === 1'b0, "R1", "pulse low after reset", {31'h0, sys_reset_req}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule